// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a 16-tap finite impulse response filter with coefficients fixed at elaboration time. It contains no multipliers. Each accepted signed input sample enters a delay line. The block then runs one bit cycle per bit of sample width. In every bit cycle it takes the same bit position from all stored samples and uses that bit slice as a table address. The tables hold precomputed sums of coefficients. The looked-up sum is weighted by its bit position and accumulated. When the last bit cycle ends, the full-precision inner product appears on the output.

The taps are split into groups of four. Each group has its own 16-entry table, and a small adder tree combines the group sums in every bit cycle. Because all bit slices are handled one per cycle, an output always takes as many cycles as the sample has bits, whatever the tap count. Samples are two's complement, so the sign-bit slice is subtracted instead of added. The block takes a new sample only while it is idle and signals this on a ready output.

Top module: `da_fir`

## Requirements
- R1: After a synchronous active-high reset, out_valid is 0, out_data is 0, in_ready is 1 and every delay-line sample is 0. The first output after reset therefore depends only on the first sample.
- R2: For each accepted sample x(n), out_data equals the sum over i = 0..15 of c_i * x(n-i). Tap 0 is the newest sample. The default coefficients c_0..c_15 are 3, -5, 12, -20, 35, 60, 90, 127, -128, 90, 60, 35, -20, 12, -5, 3, packed into COEFS with c_i at bits [8i+7:8i].
- R3: out_data is a 20-bit two's-complement result (sample width + coefficient width + log2 of the tap count). It is never truncated or wrapped, including when all samples are -128 or all are 127.
- R4: out_valid rises exactly DATA_W (8) clock edges after the edge that accepts a sample and stays high for exactly one cycle.
- R5: in_ready is 0 from the accepting edge until out_valid rises. A sample presented on in_valid while in_ready is 0 is ignored: it does not enter the delay line and does not start a computation.
- R6: Between out_valid pulses, out_data keeps the value of the last result.
- R7: Input samples are two's complement: bit 7 of in_data carries weight -128. Negative samples, including -128, contribute their signed value to the result.
- R8: in_ready is 1 in the cycle in which out_valid is 1, so a sample offered then is accepted on the next edge, giving one result every DATA_W+1 cycles under continuous input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample on in_data is offered |
| in_data | input | 8 | Signed input sample |
| in_ready | output | 1 | Block is idle and accepts a sample on this edge |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | 20 | Signed full-precision filter output |

## Verification
A unit impulse followed by zeros walks a single 1 through the delay line, so each output exposes one coefficient at a time. This separates tap ordering and table addressing errors. Runs of all -128 and all 127 drive every bit slice to all-ones or a sign pattern, which exposes a missing sign-slice subtraction or a too-narrow accumulator, and alternating extremes mix both. Random signed samples catch errors in bit weighting and group summing, while samples offered during a busy computation show whether such samples leak into the delay line.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;

endpackage

// File: rtl/da_fir_delay_line.sv
module da_fir_delay_line #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift_en,
  input  logic [DATA_W-1:0]      din,
  output logic [TAPS*DATA_W-1:0] taps_flat
);

  logic [DATA_W-1:0] stage [TAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) stage[i] <= '0;
    end else if (shift_en) begin
      stage[0] <= din;
      for (int i = 1; i < TAPS; i++) stage[i] <= stage[i-1];
    end
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_flat
    assign taps_flat[g*DATA_W +: DATA_W] = stage[g];
  end

endmodule

// File: rtl/da_fir_addr_gen.sv
module da_fir_addr_gen #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 16,
  parameter int BIT_W  = 3
) (
  input  logic [TAPS*DATA_W-1:0] taps_flat,
  input  logic [BIT_W-1:0]       bit_sel,
  output logic [TAPS-1:0]        slice
);

  for (genvar g = 0; g < TAPS; g++) begin : g_slice
    logic [DATA_W-1:0] sample;
    assign sample   = taps_flat[g*DATA_W +: DATA_W];
    assign slice[g] = sample[bit_sel];
  end

endmodule

// File: rtl/da_fir_group_rom.sv
module da_fir_group_rom #(
  parameter int                       COEF_W = 8,
  parameter int                       GROUP  = 4,
  parameter int                       ENT_W  = 10,
  parameter logic [GROUP*COEF_W-1:0]  GCOEFS = '0
) (
  input  logic [GROUP-1:0]        addr,
  output logic signed [ENT_W-1:0] entry
);

  localparam int DEPTH = 2 ** GROUP;

  function automatic logic [DEPTH*ENT_W-1:0] build_table();
    logic [DEPTH*ENT_W-1:0] tbl;
    logic signed [ENT_W-1:0] s;
    logic [COEF_W-1:0] c;
    tbl = '0;
    for (int a = 0; a < DEPTH; a++) begin
      s = '0;
      for (int t = 0; t < GROUP; t++) begin
        if (((a >> t) & 1) == 1) begin
          c = GCOEFS[t*COEF_W +: COEF_W];
          s = s + {{(ENT_W-COEF_W){c[COEF_W-1]}}, c};
        end
      end
      tbl[a*ENT_W +: ENT_W] = s;
    end
    return tbl;
  endfunction

  localparam logic [DEPTH*ENT_W-1:0] TABLE = build_table();

  assign entry = TABLE[addr*ENT_W +: ENT_W];

endmodule

// File: rtl/da_fir_sum_tree.sv
module da_fir_sum_tree #(
  parameter int GROUPS = 4,
  parameter int ENT_W  = 10,
  parameter int SUM_W  = 12
) (
  input  logic [GROUPS*ENT_W-1:0] ent_flat,
  output logic signed [SUM_W-1:0] sum
);

  always_comb begin
    sum = '0;
    for (int g = 0; g < GROUPS; g++) begin
      sum = sum + SUM_W'($signed(ent_flat[g*ENT_W +: ENT_W]));
    end
  end

endmodule

// File: rtl/da_fir_shift_acc.sv
module da_fir_shift_acc #(
  parameter int SUM_W = 12,
  parameter int ACC_W = 20,
  parameter int BIT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    first,
  input  logic                    last,
  input  logic [BIT_W-1:0]        bit_sel,
  input  logic signed [SUM_W-1:0] slice_sum,
  output logic signed [ACC_W-1:0] acc_next
);

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] term_ext;
  logic signed [ACC_W-1:0] weighted;
  logic signed [ACC_W-1:0] base;

  always_comb begin
    term_ext = ACC_W'(slice_sum);
    weighted = term_ext <<< bit_sel;
    base     = first ? '0 : acc;
    acc_next = last ? (base - weighted) : (base + weighted);
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (run) acc <= acc_next;
  end

endmodule

// File: rtl/da_fir.sv
module da_fir #(
  parameter int                       DATA_W = 8,
  parameter int                       COEF_W = 8,
  parameter int                       TAPS   = 16,
  parameter int                       GROUP  = 4,
  parameter logic [TAPS*COEF_W-1:0]   COEFS  =
    128'h03FB_0CEC_233C_5A80_7F5A_3C23_EC0C_FB03,
  localparam int                      ACC_W  = DATA_W + COEF_W + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [ACC_W-1:0]  out_data
);

  import da_fir_pkg::*;

  localparam int GROUPS = TAPS / GROUP;
  localparam int ENT_W  = COEF_W + $clog2(GROUP);
  localparam int SUM_W  = COEF_W + $clog2(TAPS);
  localparam int BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  run_state_t               state;
  logic [BIT_W-1:0]         bit_cnt;
  logic                     accept;
  logic                     first_bit;
  logic                     last_bit;
  logic                     running;
  logic [TAPS*DATA_W-1:0]   taps_flat;
  logic [TAPS-1:0]          slice;
  logic [GROUPS*ENT_W-1:0]  ent_flat;
  logic signed [SUM_W-1:0]  slice_sum;
  logic signed [ACC_W-1:0]  acc_next;

  assign accept    = in_valid && (state == ST_IDLE);
  assign running   = (state == ST_RUN);
  assign first_bit = (bit_cnt == '0);
  assign last_bit  = (bit_cnt == LAST_BIT);
  assign in_ready  = (state == ST_IDLE);

  da_fir_delay_line #(
    .DATA_W(DATA_W),
    .TAPS  (TAPS)
  ) u_dline (
    .clk      (clk),
    .rst      (rst),
    .shift_en (accept),
    .din      (in_data),
    .taps_flat(taps_flat)
  );

  da_fir_addr_gen #(
    .DATA_W(DATA_W),
    .TAPS  (TAPS),
    .BIT_W (BIT_W)
  ) u_addr (
    .taps_flat(taps_flat),
    .bit_sel  (bit_cnt),
    .slice    (slice)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_rom
    logic signed [ENT_W-1:0] entry;
    da_fir_group_rom #(
      .COEF_W(COEF_W),
      .GROUP (GROUP),
      .ENT_W (ENT_W),
      .GCOEFS(COEFS[g*GROUP*COEF_W +: GROUP*COEF_W])
    ) u_rom (
      .addr (slice[g*GROUP +: GROUP]),
      .entry(entry)
    );
    assign ent_flat[g*ENT_W +: ENT_W] = entry;
  end

  da_fir_sum_tree #(
    .GROUPS(GROUPS),
    .ENT_W (ENT_W),
    .SUM_W (SUM_W)
  ) u_tree (
    .ent_flat(ent_flat),
    .sum     (slice_sum)
  );

  da_fir_shift_acc #(
    .SUM_W(SUM_W),
    .ACC_W(ACC_W),
    .BIT_W(BIT_W)
  ) u_acc (
    .clk      (clk),
    .rst      (rst),
    .run      (running),
    .first    (first_bit),
    .last     (last_bit),
    .bit_sel  (bit_cnt),
    .slice_sum(slice_sum),
    .acc_next (acc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            state   <= ST_RUN;
            bit_cnt <= '0;
          end
        end
        default: begin
          if (last_bit) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            out_valid <= 1'b1;
            out_data  <= acc_next;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/da_fir_chk.sv
module da_fir_chk #(
  parameter int                     DATA_W = 8,
  parameter int                     COEF_W = 8,
  parameter int                     TAPS   = 16,
  parameter logic [TAPS*COEF_W-1:0] COEFS  = '0,
  parameter int                     ACC_W  = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              in_ready,
  input logic              out_valid,
  input logic [ACC_W-1:0]  out_data
);

  function automatic logic signed [63:0] abs_sum();
    logic signed [63:0] s;
    logic [COEF_W-1:0] c;
    logic signed [63:0] v;
    s = '0;
    for (int t = 0; t < TAPS; t++) begin
      c = COEFS[t*COEF_W +: COEF_W];
      v = {{(64-COEF_W){c[COEF_W-1]}}, c};
      s = s + ((v < 0) ? -v : v);
    end
    return s;
  endfunction

  localparam logic signed [63:0] BOUND = abs_sum() <<< (DATA_W - 1);

  int cnt;
  logic signed [63:0] out_ext;
  logic [DATA_W-1:0] unused_data;

  assign out_ext     = {{(64-ACC_W){out_data[ACC_W-1]}}, out_data};
  assign unused_data = in_data;

  always_ff @(posedge clk) begin
    if (rst) cnt <= 0;
    else if (in_valid && in_ready) cnt <= 1;
    else if (cnt != 0 && cnt <= DATA_W) cnt <= cnt + 1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (in_ready && !out_valid)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_ext <= BOUND && out_ext >= -BOUND)); // R3

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (cnt == DATA_W + 1)); // R4

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R4

  AST_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cnt >= 1 && cnt <= DATA_W) |-> !in_ready); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data)); // R6

  AST_READY_ON_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready); // R8

endmodule

bind da_fir da_fir_chk #(
  .DATA_W(DATA_W),
  .COEF_W(COEF_W),
  .TAPS  (TAPS),
  .COEFS (COEFS),
  .ACC_W (ACC_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_data  (in_data),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/da_fir_test.sv
module da_fir_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int NT = 16;
  localparam int AW = 20;
  localparam int COEF [NT] = '{3, -5, 12, -20, 35, 60, 90, 127,
                               -128, 90, 60, 35, -20, 12, -5, 3};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic          out_valid;
  logic [AW-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  int hist [NT];
  bit done = 1'b0;

  da_fir uut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int fir_ref();
    int s = 0;
    for (int i = 0; i < NT; i++) s += COEF[i] * hist[i];
    return s;
  endfunction

  function automatic int as_int(logic [AW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Offer one sample (assumes being at a negedge); optionally drive junk while busy.
  task automatic send(input int x, input bit junk);
    int exp;
    int cyc;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(x);
    @(posedge clk);
    for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    exp = fir_ref();
    @(negedge clk);
    check(out_valid == 1'b0, "R4 pulse width", int'(out_valid), 0);
    in_valid = junk;
    in_data  = DW'($urandom_range(255, 0));
    cyc = 0;
    while (!out_valid && cyc < 4 * DW) begin
      if (junk) check(in_ready == 1'b0, "R5 busy", int'(in_ready), 0);
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (junk) in_data = DW'($urandom_range(255, 0));
    end
    in_valid = 1'b0;
    check(cyc == DW, "R4 latency", cyc, DW);
    check(as_int(out_data) == exp, "R2 output", as_int(out_data), exp);
    check(in_ready == 1'b1, "R8 ready with result", int'(in_ready), 1);
  endtask

  initial begin
    int held;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NT; i++) hist[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(as_int(out_data) == 0, "R1 out_data", as_int(out_data), 0);

    // R1/R2: impulse walks through every tap
    send(1, 1'b0);
    check(as_int(out_data) == COEF[0], "R1 first output", as_int(out_data), COEF[0]);
    for (int k = 1; k < NT; k++) begin
      send(0, 1'b0);
      check(as_int(out_data) == COEF[k], "R2 impulse tap", as_int(out_data), COEF[k]);
    end

    // R3/R7: extreme runs
    for (int k = 0; k < NT; k++) send(-128, 1'b0);
    check(as_int(out_data) == fir_ref(), "R3 all -128", as_int(out_data), fir_ref());
    for (int k = 0; k < NT; k++) send(127, 1'b0);
    check(as_int(out_data) == fir_ref(), "R3 all 127", as_int(out_data), fir_ref());
    for (int k = 0; k < NT; k++) send((k % 2 == 0) ? -128 : 127, 1'b0);
    for (int k = 0; k < 8; k++) send(-1 - k, 1'b0);
    check(as_int(out_data) == fir_ref(), "R7 negative samples", as_int(out_data), fir_ref());

    // R6: result held between pulses
    held = as_int(out_data);
    repeat (5) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R6 no extra pulse", int'(out_valid), 0);
      check(as_int(out_data) == held, "R6 hold", as_int(out_data), held);
    end

    // R5: samples offered while busy are ignored
    for (int k = 0; k < 20; k++) send($urandom_range(255, 0) - 128, 1'b1);

    // Random stream, back-to-back (R8)
    for (int k = 0; k < 300; k++) send($urandom_range(255, 0) - 128, k[0]);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule